// File: doc/BRIEF.md
# External Bus Hold/Acknowledge Gate

This block decides, cycle by cycle, whether a DMA channel may go ahead with its next byte transfer when the external data memory bus can be shared with another bus master. Two configuration bits pick the role of this device. With neither bit set the bus is private and the channel always proceeds. In the arbiter role this device owns the bus and another master can ask for it through a hold input. In the requester role this device has to ask for the bus and may only use it once it has been acknowledged.

The sharing rules apply only when the transfer touches external data memory, either as the source or as the destination. Transfers between on-chip spaces are always permitted. The incoming hold and acknowledge pins are asynchronous. Each one passes through a flop synchronizer before it is used. In the requester role the block drives a hold request for the whole time a transfer needs external memory. In the arbiter role it drives an acknowledge back to the other master while the local channel is off the bus.

Top module: `bus_hold_gate`

## Requirements
- R1: After reset, and until the pins are seen to change, `permit` is 1 and both `hold_req_n` and `hlda_out_n` are 1. The synchronizer stages reset to 1, which is the inactive pin level.
- R2: With `cfg_arb`=0 and `cfg_req`=0, `permit` is 1 whatever the values of the pins and of the space decode.
- R3: With a role selected but `src_xmem`=0 and `dst_xmem`=0, `permit` is 1 whatever the values of the hold and acknowledge pins.
- R4: In the arbiter role with external memory involved, `permit` is 1 when the synchronized `hold_in_n` is high and 0 when it is low.
- R5: In the requester role with external memory involved, `permit` is 1 when the synchronized `hlda_in_n` is low and 0 when it is high.
- R6: A level change on `hold_in_n` or `hlda_in_n` reaches `permit` at the second rising clock edge after the change, and not at the first.
- R7: In the requester role, `hold_req_n` goes low at the first clock edge where `xfer_pending`=1 and an external space is selected. It stays high while no transfer needs external memory, and in every other role.
- R8: `hold_req_n` returns high at the clock edge that follows a cycle with `ext_access`=1 and `xfer_last`=1.
- R9: In the arbiter role, `hlda_out_n` goes low one edge after a cycle in which the synchronized hold is low and `ext_access`=0. It is high one edge after any cycle with `ext_access`=1, and it is always high outside the arbiter role.
- R10: When both role bits are 1, the arbiter role applies: `permit` follows the hold input and `hold_req_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_arb | input | 1 | Arbiter role select |
| cfg_req | input | 1 | Requester role select |
| src_xmem | input | 1 | Source space is external data memory |
| dst_xmem | input | 1 | Destination space is external data memory |
| xfer_pending | input | 1 | Channel has a transfer in progress |
| ext_access | input | 1 | Channel performs an external bus access this cycle |
| xfer_last | input | 1 | Current access is the final one of the transfer |
| hold_in_n | input | 1 | Hold request from the other master, active low, asynchronous |
| hlda_in_n | input | 1 | Hold acknowledge from the bus owner, active low, asynchronous |
| permit | output | 1 | Channel may proceed with its transfer |
| hold_req_n | output | 1 | Hold request to the bus owner, active low |
| hlda_out_n | output | 1 | Hold acknowledge to the other master, active low |

## Verification
On every cycle the assertions check four things: the unconditional grant with no role and with on-chip spaces, the denial rules for each role against the synchronized pins, that the hold request stays released outside the requester role and after a last access, and that the acknowledge only follows an idle cycle with a pending hold. Only the bench scenarios can show the exact two-edge latency from the pins, the one-edge assertion of the hold request when a transfer starts, and the role precedence seen at the ports.

// File: rtl/bhg_pkg.sv
package bhg_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_ARB  = 2'd1,
    ROLE_REQ  = 2'd2
  } bus_role_e;

  // Arbiter bit wins when both are set.
  function automatic bus_role_e decode_role(input logic arb_bit, input logic req_bit);
    if (arb_bit)      return ROLE_ARB;
    else if (req_bit) return ROLE_REQ;
    else              return ROLE_NONE;
  endfunction

endpackage

// File: rtl/bhg_sync.sv
module bhg_sync #(
  parameter int                 WIDTH   = 2,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (s == 0) begin : g_first
      assign stg_in = d;
    end else begin : g_next
      assign stg_in = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg_in;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bhg_req_ctl.sv
module bhg_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic role_is_req,
  input  logic need_xmem,
  input  logic last_xaccess,
  output logic hold_req_n
);

  logic req_on, req_on_nxt;

  always_comb begin
    req_on_nxt = req_on;
    if (!role_is_req)                 req_on_nxt = 1'b0;
    else if (req_on && last_xaccess)  req_on_nxt = 1'b0;
    else if (need_xmem)               req_on_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_on <= 1'b0;
    else        req_on <= req_on_nxt;
  end

  assign hold_req_n = ~req_on;

  // R7: no hold request in any other role
  a_r7_no_req_outside_role: assert property (@(posedge clk) disable iff (!rst_n)
    !role_is_req |=> hold_req_n);

  // R8: released after the last external access
  a_r8_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req_n && last_xaccess) |=> hold_req_n);

endmodule

// File: rtl/bhg_arb_ack.sv
module bhg_arb_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic role_is_arb,
  input  logic hold_pend,
  input  logic bus_busy,
  output logic hlda_out_n
);

  logic ack_on, ack_on_nxt;

  always_comb begin
    ack_on_nxt = role_is_arb && hold_pend && !bus_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_on <= 1'b0;
    else        ack_on <= ack_on_nxt;
  end

  assign hlda_out_n = ~ack_on;

  // R9: acknowledge only after an idle cycle with a hold pending, in arbiter role
  a_r9_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> hlda_out_n);

  a_r9_ack_only_arb: assert property (@(posedge clk) disable iff (!rst_n)
    !role_is_arb |=> hlda_out_n);

endmodule

// File: rtl/bus_hold_gate.sv
module bus_hold_gate
  import bhg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_arb,
  input  logic cfg_req,
  input  logic src_xmem,
  input  logic dst_xmem,
  input  logic xfer_pending,
  input  logic ext_access,
  input  logic xfer_last,
  input  logic hold_in_n,
  input  logic hlda_in_n,
  output logic permit,
  output logic hold_req_n,
  output logic hlda_out_n
);

  localparam int PIN_W = 2;

  bus_role_e        role;
  logic             uses_xmem;
  logic [PIN_W-1:0] pins_sync;
  logic             hold_s_n, hlda_s_n;

  assign role      = decode_role(cfg_arb, cfg_req);
  assign uses_xmem = src_xmem | dst_xmem;

  bhg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hlda_in_n, hold_in_n}),
    .q     (pins_sync)
  );

  assign hold_s_n = pins_sync[0];
  assign hlda_s_n = pins_sync[1];

  always_comb begin
    permit = 1'b1;
    if (uses_xmem) begin
      unique case (role)
        ROLE_ARB: permit = hold_s_n;
        ROLE_REQ: permit = ~hlda_s_n;
        default:  permit = 1'b1;
      endcase
    end
  end

  bhg_req_ctl u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .role_is_req  (role == ROLE_REQ),
    .need_xmem    (xfer_pending && uses_xmem),
    .last_xaccess (ext_access && xfer_last),
    .hold_req_n   (hold_req_n)
  );

  bhg_arb_ack u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_is_arb (role == ROLE_ARB),
    .hold_pend   (~hold_s_n),
    .bus_busy    (ext_access),
    .hlda_out_n  (hlda_out_n)
  );

  // R2: no role means no gating
  a_r2_free_no_role: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_arb && !cfg_req) |-> permit);

  // R3: on-chip spaces are never gated
  a_r3_free_local: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_xmem && !dst_xmem) |-> permit);

  // R4, R10: arbiter role denies while a hold is seen
  a_r4_arb_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_arb && uses_xmem && !hold_s_n) |-> !permit);

  // R5: requester role denies without acknowledge
  a_r5_req_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_arb && cfg_req && uses_xmem && hlda_s_n) |-> !permit);

endmodule

// File: tb/tb_bus_hold_gate.sv
`timescale 1ns/1ps
module tb_bus_hold_gate;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_arb, cfg_req, src_xmem, dst_xmem, xfer_pending, ext_access, xfer_last;
  logic hold_in_n, hlda_in_n;
  logic permit, hold_req_n, hlda_out_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  bus_hold_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_arb(cfg_arb), .cfg_req(cfg_req),
    .src_xmem(src_xmem), .dst_xmem(dst_xmem), .xfer_pending(xfer_pending),
    .ext_access(ext_access), .xfer_last(xfer_last), .hold_in_n(hold_in_n),
    .hlda_in_n(hlda_in_n), .permit(permit), .hold_req_n(hold_req_n),
    .hlda_out_n(hlda_out_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    cfg_arb = 0; cfg_req = 0; src_xmem = 0; dst_xmem = 0;
    xfer_pending = 0; ext_access = 0; xfer_last = 0;
    hold_in_n = 1; hlda_in_n = 1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 permit", permit, 1'b1);
    check("R1 hold_req_n", hold_req_n, 1'b1);
    check("R1 hlda_out_n", hlda_out_n, 1'b1);
  endtask

  task automatic t_no_role();
    do_reset();
    src_xmem = 1; dst_xmem = 1; hold_in_n = 0; hlda_in_n = 1;
    step(3);
    check("R2 permit no role", permit, 1'b1);
  endtask

  task automatic t_local_space();
    do_reset();
    cfg_req = 1; hlda_in_n = 1;
    step(3);
    check("R3 permit requester local", permit, 1'b1);
    cfg_req = 0; cfg_arb = 1; hold_in_n = 0;
    step(3);
    check("R3 permit arbiter local", permit, 1'b1);
  endtask

  task automatic t_arbiter();
    do_reset();
    cfg_arb = 1; src_xmem = 1;
    step(2);
    check("R4 permit hold idle", permit, 1'b1);
    hold_in_n = 0;
    step(1);
    check("R6 permit after one edge", permit, 1'b1);
    step(1);
    check("R4 permit hold seen", permit, 1'b0);
    check("R9 ack not yet", hlda_out_n, 1'b1);
    step(1);
    check("R9 ack given", hlda_out_n, 1'b0);
    ext_access = 1;
    step(1);
    check("R9 ack dropped busy", hlda_out_n, 1'b1);
    ext_access = 0; hold_in_n = 1;
    step(3);
    check("R4 permit hold gone", permit, 1'b1);
    check("R9 ack released", hlda_out_n, 1'b1);
  endtask

  task automatic t_requester();
    do_reset();
    cfg_req = 1; dst_xmem = 1;
    step(2);
    check("R5 permit no ack", permit, 1'b0);
    hlda_in_n = 0;
    step(1);
    check("R6 ack latency one edge", permit, 1'b0);
    step(1);
    check("R5 permit with ack", permit, 1'b1);
    check("R9 no ack out in requester", hlda_out_n, 1'b1);
  endtask

  task automatic t_hold_request();
    do_reset();
    cfg_req = 1;
    xfer_pending = 1;
    step(1);
    check("R7 no request local", hold_req_n, 1'b1);
    xfer_pending = 0; src_xmem = 1;
    step(1);
    check("R7 no request idle", hold_req_n, 1'b1);
    xfer_pending = 1;
    step(1);
    check("R7 request asserted", hold_req_n, 1'b0);
    ext_access = 1;
    step(1);
    check("R7 request held", hold_req_n, 1'b0);
    xfer_last = 1; xfer_pending = 0;
    step(1);
    check("R8 request released", hold_req_n, 1'b1);
    ext_access = 0; xfer_last = 0;
    step(1);
    check("R8 stays released", hold_req_n, 1'b1);
  endtask

  task automatic t_precedence();
    do_reset();
    cfg_arb = 1; cfg_req = 1; src_xmem = 1; xfer_pending = 1;
    hold_in_n = 1; hlda_in_n = 1;
    step(3);
    check("R10 permit arbiter wins", permit, 1'b1);
    check("R10 no hold request", hold_req_n, 1'b1);
    hold_in_n = 0;
    step(2);
    check("R10 permit follows hold", permit, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_role();
        t_local_space();
        t_arbiter();
        t_requester();
        t_hold_request();
        t_precedence();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule